// File: doc/BRIEF.md
# I/O Port Breakpoint Matcher

This block compares every completed port I/O access with a set of breakpoint slots (four by default). Each access arrives as a one-cycle strobe carrying the port number and a size code. The block also sees the slot address registers, the slot enable and field bits of the debug control register, the current debug status value, and a flag that says whether any I/O breakpoint is armed. When at least one armed I/O slot overlaps the accessed bytes, the block issues a one-cycle debug-trap request. In the same cycle it gives the mask of the slots that hit, and a new status value whose low bits hold that mask.

The trap is taken after the instruction completes, so the core resumes at the next instruction. A repeated string I/O instruction presents one strobe per iteration, and each iteration is checked on its own. The overlap test is inclusive at both ends. It is computed one bit wider than the address registers, so an access that runs past the top port number cannot wrap around and alias to low addresses.

Top module: `iobrk_matcher`

## Requirements
- R1: While reset is high, and in the first cycle after it, `trap_req` is 0, `hit_mask` is 0 and `status_out` is 0.
- R2: Slot i can hit only if its type field `ctrl_fields[4i+1:4i]` equals 2'b10 (I/O read/write) and at least one of its enables is set: local `ctrl_en[2i]` or global `ctrl_en[2i+1]`. Either enable on its own is enough. Type codes 00, 01 and 11 never hit.
- R3: The slot length code `ctrl_fields[4i+3:4i+2]` maps to a byte count: 0 gives 1 byte, 1 gives 2 bytes, 2 gives 8 bytes, 3 gives 4 bytes.
- R4: The access size code `acc_size` covers 1<<code bytes: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8.
- R5: A slot hits when port+size-1 >= address and port <= address+length-1. Both end bytes count as overlap.
- R6: The overlap sums are computed one bit wider than the address, with no truncation. Port 0xFFFF with size 2 therefore reaches byte 0x10000.
- R7: On a hit, `status_out` bits [NUM_SLOTS-1:0] equal the hit mask and the upper bits equal `status_in` sampled with the access.
- R8: `trap_req` and `hit_mask` are registered. They are asserted exactly one cycle after an access that hits and are 0 in every other cycle. `trap_req` is high exactly when `hit_mask` is non-zero.
- R9: When `io_bp_en` is 0, or `acc_valid` is 0, no trap is raised and `status_out` keeps its previous value.
- R10: Several slots can hit in the same access, and every hitting slot's bit is set in `hit_mask`.
- R11: Accesses on back-to-back cycles, as in a string I/O instruction, are each checked independently and give back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | One-cycle strobe for a completed port access |
| acc_port | input | PORT_W | Port number of the access |
| acc_size | input | 2 | Size code; the access covers 1<<code bytes |
| io_bp_en | input | 1 | Global flag: at least one I/O breakpoint is armed |
| ctrl_en | input | 2*NUM_SLOTS | Per-slot enables: local at 2i, global at 2i+1 |
| ctrl_fields | input | 4*NUM_SLOTS | Per-slot nibble: type in [1:0], length code in [3:2] |
| slot_addr | input | ADDR_W*NUM_SLOTS | Slot address registers, slot i at [ADDR_W*i +: ADDR_W] |
| status_in | input | STAT_W | Current debug status value |
| trap_req | output | 1 | One-cycle debug-trap request, taken after the instruction |
| hit_mask | output | NUM_SLOTS | Slots that hit, valid while trap_req is high |
| status_out | output | STAT_W | Updated status value; holds between hits |

## Verification
Most faults in this block show up one cycle after the access strobe. A wrong slot decode or length decode shows as a wrong bit in `hit_mask`. An overlap comparison off by one, or a sum that wraps, shows at the edge bytes of a slot: a hit is missed or a spurious hit appears on the byte next to the range. A fault in the result register shows in how the outputs look over time: the trap is late or lasts more than one cycle, or `status_out` changes when it should hold. The tests therefore probe the first and last bytes of each slot together with their outer neighbours, and check that the trap has dropped in the cycle after it was raised.

// File: rtl/iobrk_pkg.sv
package iobrk_pkg;

    localparam int BYTES_W = 4;
    localparam logic [1:0] KIND_IO = 2'b10;

    typedef logic [BYTES_W-1:0] nbytes_t;

    typedef struct packed {
        logic    armed;
        logic    is_io;
        nbytes_t span;
    } slot_cfg_t;

    // Slot length code to byte count; code 2 is the eight-byte case.
    function automatic nbytes_t span_of(input logic [1:0] code);
        nbytes_t r;
        case (code)
            2'd0:    r = nbytes_t'(1);
            2'd1:    r = nbytes_t'(2);
            2'd2:    r = nbytes_t'(8);
            default: r = nbytes_t'(4);
        endcase
        return r;
    endfunction

    // Access size code to byte count: 1 << code.
    function automatic nbytes_t size_of(input logic [1:0] code);
        return nbytes_t'(1) << code;
    endfunction

endpackage

// File: rtl/iobrk_slot_decode.sv
module iobrk_slot_decode
    import iobrk_pkg::*;
(
    input  logic [1:0] en_pair,
    input  logic [3:0] field_nib,
    output slot_cfg_t  cfg
);
    always_comb begin
        cfg.armed = en_pair[0] | en_pair[1];
        cfg.is_io = (field_nib[1:0] == KIND_IO);
        cfg.span  = span_of(field_nib[3:2]);
    end
endmodule

// File: rtl/iobrk_range_cmp.sv
module iobrk_range_cmp
    import iobrk_pkg::*;
#(
    parameter int PORT_W = 16,
    parameter int ADDR_W = 32
) (
    input  logic [PORT_W-1:0] port,
    input  nbytes_t           acc_bytes,
    input  logic [ADDR_W-1:0] base,
    input  nbytes_t           slot_bytes,
    output logic              overlap
);
    localparam int CW = ADDR_W + 1;

    logic [CW-1:0] acc_lo, acc_hi, slot_lo, slot_hi;

    always_comb begin
        acc_lo  = CW'(port);
        acc_hi  = acc_lo + CW'(acc_bytes) - CW'(1);
        slot_lo = CW'(base);
        slot_hi = slot_lo + CW'(slot_bytes) - CW'(1);
        overlap = (acc_hi >= slot_lo) && (acc_lo <= slot_hi);
    end
endmodule

// File: rtl/iobrk_result_reg.sv
module iobrk_result_reg #(
    parameter int NUM_SLOTS = 4,
    parameter int STAT_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SLOTS-1:0] hit_vec,
    input  logic [STAT_W-1:0]    status_next,
    output logic                 trap_q,
    output logic [NUM_SLOTS-1:0] mask_q,
    output logic [STAT_W-1:0]    status_q
);
    logic any_hit;
    assign any_hit = |hit_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_q   <= 1'b0;
            mask_q   <= '0;
            status_q <= '0;
        end else begin
            trap_q <= any_hit;
            mask_q <= hit_vec;
            if (any_hit) begin
                status_q <= status_next;
            end
        end
    end
endmodule

// File: rtl/iobrk_matcher.sv
module iobrk_matcher
    import iobrk_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int PORT_W    = 16,
    parameter int ADDR_W    = 32,
    parameter int STAT_W    = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        acc_valid,
    input  logic [PORT_W-1:0]           acc_port,
    input  logic [1:0]                  acc_size,
    input  logic                        io_bp_en,
    input  logic [2*NUM_SLOTS-1:0]      ctrl_en,
    input  logic [4*NUM_SLOTS-1:0]      ctrl_fields,
    input  logic [ADDR_W*NUM_SLOTS-1:0] slot_addr,
    input  logic [STAT_W-1:0]           status_in,
    output logic                        trap_req,
    output logic [NUM_SLOTS-1:0]        hit_mask,
    output logic [STAT_W-1:0]           status_out
);
    localparam logic [STAT_W-1:0] LOW_MASK = STAT_W'({NUM_SLOTS{1'b1}});

    nbytes_t               acc_bytes;
    slot_cfg_t             cfg   [NUM_SLOTS];
    logic [NUM_SLOTS-1:0]  overlap;
    logic [NUM_SLOTS-1:0]  hit_vec;
    logic                  check_now;
    logic [STAT_W-1:0]     status_next;

    assign acc_bytes = size_of(acc_size);
    assign check_now = acc_valid & io_bp_en;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        iobrk_slot_decode u_dec (
            .en_pair   (ctrl_en[2*i +: 2]),
            .field_nib (ctrl_fields[4*i +: 4]),
            .cfg       (cfg[i])
        );

        iobrk_range_cmp #(
            .PORT_W (PORT_W),
            .ADDR_W (ADDR_W)
        ) u_cmp (
            .port       (acc_port),
            .acc_bytes  (acc_bytes),
            .base       (slot_addr[ADDR_W*i +: ADDR_W]),
            .slot_bytes (cfg[i].span),
            .overlap    (overlap[i])
        );

        assign hit_vec[i] = check_now & cfg[i].armed & cfg[i].is_io & overlap[i];
    end

    assign status_next = (status_in & ~LOW_MASK) | STAT_W'(hit_vec);

    iobrk_result_reg #(
        .NUM_SLOTS (NUM_SLOTS),
        .STAT_W    (STAT_W)
    ) u_res (
        .clk         (clk),
        .rst         (rst),
        .hit_vec     (hit_vec),
        .status_next (status_next),
        .trap_q      (trap_req),
        .mask_q      (hit_mask),
        .status_q    (status_out)
    );
endmodule

// File: rtl/iobrk_matcher_chk.sv
module iobrk_matcher_chk #(
    parameter int NUM_SLOTS = 4,
    parameter int STAT_W    = 32
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          acc_valid,
    input logic                          io_bp_en,
    input logic [2*NUM_SLOTS-1:0]        ctrl_en,
    input logic [4*NUM_SLOTS-1:0]        ctrl_fields,
    input logic [STAT_W-1:NUM_SLOTS]     status_hi,
    input logic                          trap_req,
    input logic [NUM_SLOTS-1:0]          hit_mask,
    input logic [STAT_W-1:0]             status_out
);
    logic [NUM_SLOTS-1:0] eligible;
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_el
        assign eligible[i] = (ctrl_en[2*i] | ctrl_en[2*i+1]) &&
                             (ctrl_fields[4*i +: 2] == 2'b10);
    end

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (!trap_req && hit_mask == '0));

    assert_eligible_R2: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> ((hit_mask & ~$past(eligible)) == '0));

    assert_status_low_R7: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> (status_out[NUM_SLOTS-1:0] == hit_mask));

    assert_status_upper_R7: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> (status_out[STAT_W-1:NUM_SLOTS] == $past(status_hi)));

    assert_trap_has_mask_R8: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> (hit_mask != '0));

    assert_mask_needs_trap_R8: assert property (@(posedge clk) disable iff (rst)
        !trap_req |-> (hit_mask == '0));

    assert_gate_R9: assert property (@(posedge clk) disable iff (rst)
        (!acc_valid || !io_bp_en) |=> !trap_req);

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!acc_valid || !io_bp_en) |=> $stable(status_out));
endmodule

bind iobrk_matcher iobrk_matcher_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .STAT_W    (STAT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .acc_valid   (acc_valid),
    .io_bp_en    (io_bp_en),
    .ctrl_en     (ctrl_en),
    .ctrl_fields (ctrl_fields),
    .status_hi   (status_in[STAT_W-1:NUM_SLOTS]),
    .trap_req    (trap_req),
    .hit_mask    (hit_mask),
    .status_out  (status_out)
);

// File: tb/test_iobrk_matcher.sv
module test_iobrk_matcher;
    localparam int NS = 4;
    localparam int PW = 16;
    localparam int AW = 32;
    localparam int SW = 32;

    logic            clk = 1'b0;
    logic            rst;
    logic            acc_valid;
    logic [PW-1:0]   acc_port;
    logic [1:0]      acc_size;
    logic            io_bp_en;
    logic [2*NS-1:0] ctrl_en;
    logic [4*NS-1:0] ctrl_fields;
    logic [AW*NS-1:0] slot_addr;
    logic [SW-1:0]   status_in;
    logic            trap_req;
    logic [NS-1:0]   hit_mask;
    logic [SW-1:0]   status_out;

    int vec_cnt = 0;
    int err_cnt = 0;
    logic [SW-1:0] exp_status;
    logic done = 1'b0;

    always #5 clk = ~clk;

    iobrk_matcher #(
        .NUM_SLOTS (NS),
        .PORT_W    (PW),
        .ADDR_W    (AW),
        .STAT_W    (SW)
    ) i_iobrk_matcher (
        .clk         (clk),
        .rst         (rst),
        .acc_valid   (acc_valid),
        .acc_port    (acc_port),
        .acc_size    (acc_size),
        .io_bp_en    (io_bp_en),
        .ctrl_en     (ctrl_en),
        .ctrl_fields (ctrl_fields),
        .slot_addr   (slot_addr),
        .status_in   (status_in),
        .trap_req    (trap_req),
        .hit_mask    (hit_mask),
        .status_out  (status_out)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vec_cnt++;
        if (act !== exp) begin
            err_cnt++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_slot(input int i, input logic [1:0] kind, input logic [1:0] len,
                            input logic loc, input logic glb, input logic [AW-1:0] a);
        ctrl_fields[4*i +: 4] = {len, kind};
        ctrl_en[2*i]          = loc;
        ctrl_en[2*i+1]        = glb;
        slot_addr[AW*i +: AW] = a;
    endtask

    task automatic clear_slots();
        ctrl_en     = '0;
        ctrl_fields = '0;
        slot_addr   = '0;
    endtask

    // Presents one access; results are sampled after the registering edge.
    task automatic access(input string req, input logic [PW-1:0] p,
                          input logic [1:0] code, input logic [NS-1:0] exp_mask);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_port  = p;
        acc_size  = code;
        @(posedge clk);
        #2;
        chk(req, 64'(trap_req), 64'(exp_mask != '0));
        chk(req, 64'(hit_mask), 64'(exp_mask));
        if (exp_mask != '0) exp_status = {status_in[SW-1:NS], exp_mask};
        chk(req, 64'(status_out), 64'(exp_status));
    endtask

    task automatic go_idle(input string req);
        @(negedge clk);
        acc_valid = 1'b0;
        @(posedge clk);
        #2;
        chk(req, 64'(trap_req), 64'(0));
        chk(req, 64'(hit_mask), 64'(0));
        chk(req, 64'(status_out), 64'(exp_status));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        acc_valid = 1'b1; acc_port = '0; acc_size = '0; io_bp_en = 1'b1;
        clear_slots();
        set_slot(0, 2'b10, 2'd0, 1'b1, 1'b0, 32'h0);
        status_in = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #2;
        exp_status = '0;
        chk("R1 trap in reset", 64'(trap_req), 64'(0));
        chk("R1 mask in reset", 64'(hit_mask), 64'(0));
        chk("R1 status in reset", 64'(status_out), 64'(0));
        @(negedge clk);
        rst = 1'b0;
        acc_valid = 1'b0;
        clear_slots();
        @(posedge clk);
        #2;
        chk("R1 trap after reset", 64'(trap_req), 64'(0));
        chk("R1 status after reset", 64'(status_out), 64'(0));
    endtask

    task automatic t_kind_enable();
        clear_slots();
        io_bp_en  = 1'b1;
        status_in = 32'hDEAD_BEE0;
        set_slot(0, 2'b00, 2'd0, 1'b1, 1'b1, 32'h80);
        access("R2 type 00", 16'h80, 2'd0, 4'b0000);
        set_slot(0, 2'b01, 2'd0, 1'b1, 1'b1, 32'h80);
        access("R2 type 01", 16'h80, 2'd0, 4'b0000);
        set_slot(0, 2'b11, 2'd0, 1'b1, 1'b1, 32'h80);
        access("R2 type 11", 16'h80, 2'd0, 4'b0000);
        set_slot(0, 2'b10, 2'd0, 1'b0, 1'b0, 32'h80);
        access("R2 io disabled", 16'h80, 2'd0, 4'b0000);
        set_slot(0, 2'b10, 2'd0, 1'b1, 1'b0, 32'h80);
        access("R2 R7 local only", 16'h80, 2'd0, 4'b0001);
        go_idle("R8 pulse ends");
        set_slot(0, 2'b10, 2'd0, 1'b0, 1'b1, 32'h80);
        access("R2 global only", 16'h80, 2'd0, 4'b0001);
        go_idle("R8 pulse ends");
    endtask

    task automatic t_length();
        clear_slots();
        status_in = 32'h1234_5679;
        set_slot(1, 2'b10, 2'd2, 1'b0, 1'b1, 32'h100);
        access("R3 len8 last", 16'h107, 2'd0, 4'b0010);
        access("R3 len8 past", 16'h108, 2'd0, 4'b0000);
        access("R5 below start", 16'h0FF, 2'd0, 4'b0000);
        set_slot(1, 2'b10, 2'd3, 1'b0, 1'b1, 32'h100);
        access("R3 len4 last", 16'h103, 2'd0, 4'b0010);
        access("R3 len4 past", 16'h104, 2'd0, 4'b0000);
        set_slot(1, 2'b10, 2'd1, 1'b0, 1'b1, 32'h100);
        access("R3 len2 last", 16'h101, 2'd0, 4'b0010);
        access("R3 len2 past", 16'h102, 2'd0, 4'b0000);
        set_slot(1, 2'b10, 2'd0, 1'b0, 1'b1, 32'h100);
        access("R3 len1 first", 16'h100, 2'd0, 4'b0010);
        access("R3 len1 past", 16'h101, 2'd0, 4'b0000);
        go_idle("R8 idle");
    endtask

    task automatic t_size();
        clear_slots();
        status_in = 32'hA5A5_0000;
        set_slot(2, 2'b10, 2'd0, 1'b1, 1'b0, 32'h200);
        access("R4 size2 reaches", 16'h1FF, 2'd1, 4'b0100);
        access("R4 size1 short", 16'h1FF, 2'd0, 4'b0000);
        access("R4 size4 reaches", 16'h1FD, 2'd2, 4'b0100);
        access("R4 size4 short", 16'h1FC, 2'd2, 4'b0000);
        access("R4 size8 reaches", 16'h1F9, 2'd3, 4'b0100);
        access("R5 size8 short", 16'h1F8, 2'd3, 4'b0000);
        go_idle("R8 idle");
    endtask

    task automatic t_wrap();
        clear_slots();
        status_in = 32'h0F0F_0F00;
        set_slot(3, 2'b10, 2'd0, 1'b1, 1'b0, 32'h0001_0000);
        access("R6 top port spans", 16'hFFFF, 2'd1, 4'b1000);
        access("R6 top port single", 16'hFFFF, 2'd0, 4'b0000);
        set_slot(3, 2'b10, 2'd0, 1'b1, 1'b0, 32'h0000_0001);
        access("R6 no alias low", 16'hFFFF, 2'd2, 4'b0000);
        go_idle("R8 idle");
    endtask

    task automatic t_gate();
        clear_slots();
        set_slot(0, 2'b10, 2'd0, 1'b1, 1'b1, 32'h60);
        io_bp_en  = 1'b0;
        status_in = 32'h7777_7770;
        access("R9 flag off", 16'h60, 2'd0, 4'b0000);
        go_idle("R9 hold");
        io_bp_en = 1'b1;
    endtask

    task automatic t_multi();
        clear_slots();
        status_in = 32'hCAFE_F00F;
        set_slot(0, 2'b10, 2'd3, 1'b1, 1'b0, 32'h300);
        set_slot(1, 2'b10, 2'd0, 1'b0, 1'b1, 32'h302);
        set_slot(2, 2'b00, 2'd3, 1'b1, 1'b1, 32'h300);
        set_slot(3, 2'b10, 2'd1, 1'b1, 1'b0, 32'h303);
        access("R10 three slots", 16'h301, 2'd2, 4'b1011);
        go_idle("R8 idle");
    endtask

    task automatic t_burst();
        // keeps the configuration from t_multi; valid stays high across accesses
        status_in = 32'h5555_AAA0;
        access("R11 iter1", 16'h300, 2'd0, 4'b0001);
        access("R11 iter2 miss", 16'h400, 2'd0, 4'b0000);
        status_in = 32'h3333_CCC0;
        access("R11 iter3", 16'h302, 2'd0, 4'b0011);
        access("R11 iter4", 16'h304, 2'd0, 4'b1000);
        go_idle("R11 end");
    endtask

    initial begin
        t_reset();
        t_kind_enable();
        t_length();
        t_size();
        t_wrap();
        t_gate();
        t_multi();
        t_burst();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            vec_cnt++;
            err_cnt++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
            $finish;
        end
    end
endmodule